// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block is the digital controller for an eight-input, ten-bit successive-approximation converter. Software-side writes load a channel code, an enable mask for the inputs that are wired as analog pins, and a start strobe. When a start is accepted, the block waits a fixed number of clocks and then raises the sample/hold control. After sampling it resolves the held voltage one bit per clock, from the most significant bit down. In each of those clocks it presents a trial code to the DAC and reads back a comparator decision.

When the last bit is decided, the block loads the ten-bit result and a validity flag, drops its busy indication and raises a sticky completion flag. The flag stays set until it is cleared with a write of one. The validity flag marks a result as unusable when the channel chosen at start time is not enabled in the analog-pin mask. The analog multiplexer, sample/hold, DAC and comparator sit outside this block.

Top module: `sar_adc_seq`

## Requirements
- R1: The channel code is plain binary, bit 2 being the most significant: code k selects input k. `mux_sel` carries the code captured at start throughout the conversion.
- R2: A `start_wr` pulse while idle is accepted at that clock edge. `busy` is high from the next cycle, and the channel register value at that edge is captured.
- R3: `sh_sample` rises exactly START_DLY cycles after the accepting edge and stays high for exactly SAMP_CYC cycles.
- R4: Bit trials run most significant bit first. The first DAC code after sampling is 0x200. While idle, `dac_code` is 0 and `sh_sample` is low.
- R5: In each trial the tested bit is set to 1 in `dac_code`. That bit is kept when `comp_ge` is 1 (input at or above the DAC level) and cleared otherwise. With an ideal comparator the result therefore equals the sampled input code.
- R6: `result` is ten bits, bit 0 the LSB and bit 9 the MSB. It changes only at the edge where `busy` falls, which is START_DLY+SAMP_CYC+10 cycles after the accepting edge.
- R7: A `start_wr` pulse while `busy` is high is ignored. It changes neither the channel, the timing nor the result.
- R8: `done` is set when the result is loaded and stays set until a cycle with `done_clr` high clears it.
- R9: Writes to the channel register during a conversion do not affect `mux_sel` or the result of that conversion.
- R10: `result_invalid` is loaded with the result and is 1 exactly when the mask bit of the channel captured at start was 0. Any number of mask bits may be set, and mask writes during a conversion do not alter the flag.
- R11: After reset, `busy`, `done`, `result`, `result_invalid`, `mux_sel`, `sh_sample` and `dac_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_wr | input | 1 | Write strobe for the channel register |
| chan_wdata | input | 3 | Channel code to write |
| mask_wr | input | 1 | Write strobe for the analog-pin enable mask |
| mask_wdata | input | 8 | Mask value; bit k enables input k |
| start_wr | input | 1 | Start strobe (write of one) |
| done_clr | input | 1 | Clears `done` when high |
| comp_ge | input | 1 | Comparator: held input is at or above the DAC level |
| mux_sel | output | 3 | Analog multiplexer select |
| sh_sample | output | 1 | Sample/hold control, high while sampling |
| dac_code | output | 10 | DAC trial code |
| busy | output | 1 | Conversion in progress |
| result | output | 10 | Last conversion result |
| result_invalid | output | 1 | Last result came from a channel that was not enabled |
| done | output | 1 | Sticky completion flag |

## Verification
On every cycle the assertions check the cycle-local rules: a start is accepted when idle, the multiplexer select holds during a conversion, the first trial after sampling is the MSB code, and the idle outputs are quiet. They also check that the result only moves when busy falls and that done stays set until cleared. The exact start-to-sample delay, the width of the sample window, the total conversion length and the bit-by-bit decisions that make the result equal the held input can only be shown by the bench's scenarios. The same holds for the mask check against each channel and for the writes injected mid-conversion, which the bench runs against a sample/hold and comparator model.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int SAR_BITS = 10;
    localparam int NUM_CH   = 8;
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int IDX_W    = $clog2(SAR_BITS);

    typedef logic [SAR_BITS-1:0] code_t;
    typedef logic [CH_W-1:0]     ch_t;
    typedef logic [NUM_CH-1:0]   mask_t;
    typedef logic [IDX_W-1:0]    idx_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SAMP,
        ST_CONV
    } seq_state_e;

    typedef struct packed {
        logic busy;
        logic start_acc;
        logic sample;
        logic convert;
        logic last_bit;
        idx_t bit_idx;
    } seq_ctl_t;

    typedef struct packed {
        code_t value;
        logic  invalid;
    } result_t;

    function automatic code_t trial_bit(input idx_t idx);
        return code_t'(1) << idx;
    endfunction

endpackage

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_pkg::*;
#(
    parameter int START_DLY = 4,
    parameter int SAMP_CYC  = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_wr,
    output seq_ctl_t ctl
);

    localparam int CNT_MAX = (START_DLY > SAMP_CYC) ? START_DLY : SAMP_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    idx_t             idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_wr) begin
                        state_q <= ST_WAIT;
                        cnt_q   <= CNT_W'(START_DLY - 1);
                    end
                end
                ST_WAIT: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_SAMP;
                        cnt_q   <= CNT_W'(SAMP_CYC - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_SAMP: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_CONV;
                        idx_q   <= idx_t'(SAR_BITS - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_CONV: begin
                    if (idx_q == '0) begin
                        state_q <= ST_IDLE;
                    end else begin
                        idx_q <= idx_q - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.busy      = (state_q != ST_IDLE);
        ctl.start_acc = (state_q == ST_IDLE) && start_wr;
        ctl.sample    = (state_q == ST_SAMP);
        ctl.convert   = (state_q == ST_CONV);
        ctl.last_bit  = (state_q == ST_CONV) && (idx_q == '0);
        ctl.bit_idx   = idx_q;
    end

endmodule

// File: rtl/sar_cfg_regs.sv
module sar_cfg_regs
    import sar_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic chan_wr,
    input  ch_t  chan_wdata,
    input  logic mask_wr,
    input  mask_t mask_wdata,
    input  logic start_acc,
    output ch_t  act_ch,
    output logic act_bad
);

    ch_t   chan_q;
    mask_t mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q  <= '0;
            mask_q  <= '0;
            act_ch  <= '0;
            act_bad <= 1'b0;
        end else begin
            if (chan_wr) chan_q <= chan_wdata;
            if (mask_wr) mask_q <= mask_wdata;
            if (start_acc) begin
                act_ch  <= chan_q;
                act_bad <= ~mask_q[chan_q];
            end
        end
    end

endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg
    import sar_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  seq_ctl_t ctl,
    input  logic     comp_ge,
    output code_t    dac_code,
    output code_t    decided
);

    code_t sar_q;
    code_t nxt;

    // One decision slot per bit: only the bit under trial takes the comparator.
    for (genvar b = 0; b < SAR_BITS; b++) begin : g_bit
        assign nxt[b] = (ctl.convert && (ctl.bit_idx == idx_t'(b))) ? comp_ge : sar_q[b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sar_q <= '0;
        end else if (ctl.sample) begin
            sar_q <= '0;
        end else if (ctl.convert) begin
            sar_q <= nxt;
        end
    end

    assign dac_code = ctl.convert ? (sar_q | trial_bit(ctl.bit_idx)) : '0;
    assign decided  = nxt;

endmodule

// File: rtl/sar_result_regs.sv
module sar_result_regs
    import sar_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  code_t   decided,
    input  logic    bad,
    input  logic    done_clr,
    output result_t res,
    output logic    done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            res  <= '0;
            done <= 1'b0;
        end else begin
            if (load) begin
                res.value   <= decided;
                res.invalid <= bad;
            end
            if (load)          done <= 1'b1;
            else if (done_clr) done <= 1'b0;
        end
    end

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
    import sar_pkg::*;
#(
    parameter int START_DLY = 4,
    parameter int SAMP_CYC  = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                chan_wr,
    input  logic [CH_W-1:0]     chan_wdata,
    input  logic                mask_wr,
    input  logic [NUM_CH-1:0]   mask_wdata,
    input  logic                start_wr,
    input  logic                done_clr,
    input  logic                comp_ge,
    output logic [CH_W-1:0]     mux_sel,
    output logic                sh_sample,
    output logic [SAR_BITS-1:0] dac_code,
    output logic                busy,
    output logic [SAR_BITS-1:0] result,
    output logic                result_invalid,
    output logic                done
);

    seq_ctl_t ctl;
    logic     act_bad;
    code_t    decided;
    result_t  res;

    sar_seq_fsm #(
        .START_DLY (START_DLY),
        .SAMP_CYC  (SAMP_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start_wr (start_wr),
        .ctl      (ctl)
    );

    sar_cfg_regs u_cfg (
        .clk        (clk),
        .rst        (rst),
        .chan_wr    (chan_wr),
        .chan_wdata (chan_wdata),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .start_acc  (ctl.start_acc),
        .act_ch     (mux_sel),
        .act_bad    (act_bad)
    );

    sar_approx_reg u_sar (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .comp_ge  (comp_ge),
        .dac_code (dac_code),
        .decided  (decided)
    );

    sar_result_regs u_res (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.last_bit),
        .decided  (decided),
        .bad      (act_bad),
        .done_clr (done_clr),
        .res      (res),
        .done     (done)
    );

    assign sh_sample      = ctl.sample;
    assign busy           = ctl.busy;
    assign result         = res.value;
    assign result_invalid = res.invalid;

endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk
    import sar_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                chan_wr,
    input logic                start_wr,
    input logic                done_clr,
    input logic [CH_W-1:0]     mux_sel,
    input logic                sh_sample,
    input logic [SAR_BITS-1:0] dac_code,
    input logic                busy,
    input logic [SAR_BITS-1:0] result,
    input logic                done
);

    localparam code_t MSB_TRIAL = code_t'(1) << (SAR_BITS - 1);

    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_wr) |=> busy);

    p_no_early_sample_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !sh_sample);

    p_msb_first_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(sh_sample) |-> (dac_code == MSB_TRIAL));

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (dac_code == '0 && !sh_sample));

    p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !$fell(busy) |-> $stable(result));

    p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && start_wr) |=> $stable(mux_sel));

    p_done_on_end_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !done_clr) |=> done);

    p_chan_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && chan_wr) |=> $stable(mux_sel));

    p_sel_steady_r1: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mux_sel));

endmodule

bind sar_adc_seq sar_adc_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .chan_wr   (chan_wr),
    .start_wr  (start_wr),
    .done_clr  (done_clr),
    .mux_sel   (mux_sel),
    .sh_sample (sh_sample),
    .dac_code  (dac_code),
    .busy      (busy),
    .result    (result),
    .done      (done)
);

// File: tb/tb_sar_adc_seq.sv
`timescale 1ns/1ps
module tb_sar_adc_seq;

    localparam int D = 4;
    localparam int S = 3;
    localparam int TOTAL = D + S + 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chan_wr = 1'b0;
    logic [2:0] chan_wdata = '0;
    logic       mask_wr = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic       start_wr = 1'b0;
    logic       done_clr = 1'b0;
    logic       comp_ge;
    logic [2:0] mux_sel;
    logic       sh_sample;
    logic [9:0] dac_code;
    logic       busy;
    logic [9:0] result;
    logic       result_invalid;
    logic       done;

    int checks = 0;
    int errors = 0;

    logic [9:0] vin [8];
    logic [9:0] held = '0;
    logic [7:0] mask_m = '0;
    logic [2:0] chan_m = '0;

    always #10 clk = ~clk;

    sar_adc_seq #(.START_DLY(D), .SAMP_CYC(S)) dut (
        .clk(clk), .rst(rst), .chan_wr(chan_wr), .chan_wdata(chan_wdata),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .start_wr(start_wr),
        .done_clr(done_clr), .comp_ge(comp_ge), .mux_sel(mux_sel),
        .sh_sample(sh_sample), .dac_code(dac_code), .busy(busy),
        .result(result), .result_invalid(result_invalid), .done(done)
    );

    // Behavioural sample/hold and ideal comparator.
    always @(posedge clk) if (sh_sample) held <= vin[mux_sel];
    assign comp_ge = (held >= dac_code);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_chan(input logic [2:0] c);
        chan_wr = 1'b1; chan_wdata = c;
        @(posedge clk); @(negedge clk);
        chan_wr = 1'b0; chan_m = c;
    endtask

    task automatic write_mask(input logic [7:0] m);
        mask_wr = 1'b1; mask_wdata = m;
        @(posedge clk); @(negedge clk);
        mask_wr = 1'b0; mask_m = m;
    endtask

    task automatic clear_done();
        done_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        done_clr = 1'b0;
        chk(done == 1'b0, "R8", "done after clear", int'(done), 0);
    endtask

    // Runs one conversion on the channel already in the register; called at a negedge.
    task automatic run_conv(input bit inj_start, input bit inj_chan,
                            input bit inj_mask, input bit chg_vin);
        int n = 0;
        int s_first = -1;
        int s_cnt = 0;
        logic [9:0] first_trial = '0;
        logic [2:0] ch = chan_m;
        logic [9:0] exp_val = vin[chan_m];
        bit exp_bad = ~mask_m[chan_m];
        logic [2:0] sel_seen = '0;
        start_wr = 1'b1;
        @(posedge clk);
        forever begin
            @(negedge clk);
            start_wr = 1'b0; chan_wr = 1'b0; mask_wr = 1'b0;
            if (sh_sample) begin
                if (s_first < 0) s_first = n;
                s_cnt++;
            end
            if (n == D) sel_seen = mux_sel;
            if (n == D + S) first_trial = dac_code;
            if (!busy || n > 400) break;
            if (n == 2) begin
                if (inj_start) start_wr = 1'b1;
                if (inj_chan) begin
                    chan_wr = 1'b1; chan_wdata = ch + 3'd1; chan_m = ch + 3'd1;
                end
                if (inj_mask) begin
                    mask_wr = 1'b1; mask_wdata = mask_m ^ (8'd1 << ch);
                    mask_m = mask_m ^ (8'd1 << ch);
                end
            end
            if (chg_vin && n == D + S + 2) vin[ch] = ~vin[ch];
            @(posedge clk);
            n++;
        end
        chk(n == TOTAL, "R6", "busy length", n, TOTAL);
        chk(s_first == D, "R3", "sample start", s_first, D);
        chk(s_cnt == S, "R3", "sample width", s_cnt, S);
        chk(sel_seen == ch, "R1", "mux_sel", int'(sel_seen), int'(ch));
        chk(first_trial == 10'h200, "R4", "first trial", int'(first_trial), 'h200);
        chk(result == exp_val, inj_start ? "R7" : (inj_chan ? "R9" : "R5"),
            "result", int'(result), int'(exp_val));
        chk(result_invalid == exp_bad, "R10", "invalid", int'(result_invalid), int'(exp_bad));
        chk(done == 1'b1, "R8", "done set", int'(done), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 8; i++) vin[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk(!busy && !done && !sh_sample, "R11", "flags", int'({busy, done, sh_sample}), 0);
        chk(result == '0 && !result_invalid, "R11", "result", int'(result), 0);
        chk(mux_sel == '0 && dac_code == '0, "R11", "sel/dac", int'(dac_code), 0);

        // Directed: boundary codes, mask with several bits
        vin[0] = 10'd0; vin[7] = 10'h3ff; vin[3] = 10'h200; vin[4] = 10'h1ff;
        write_mask(8'b1001_1001);
        write_chan(3'd0); run_conv(0, 0, 0, 0); clear_done();
        write_chan(3'd7); run_conv(0, 0, 0, 0);
        write_chan(3'd3); run_conv(0, 0, 0, 0); clear_done();
        write_chan(3'd4); run_conv(0, 0, 0, 0); clear_done();

        // R10 mismatch: only input 5 enabled, input 4 selected
        write_mask(8'b0010_0000);
        run_conv(0, 0, 0, 0); clear_done();
        // R10 mask write mid-conversion does not change the flag
        write_chan(3'd5); run_conv(0, 0, 1, 0); clear_done();

        // R7 start while busy, R9 channel write while busy
        vin[1] = 10'd613; vin[2] = 10'd77; vin[6] = 10'd900;
        write_mask(8'hff);
        write_chan(3'd1); run_conv(1, 0, 0, 0); clear_done();
        write_chan(3'd1); run_conv(0, 1, 0, 0); clear_done();
        // Hold: input changes after sampling
        write_chan(3'd6); run_conv(0, 0, 0, 1); clear_done();

        // Constrained random
        for (int k = 0; k < 30; k++) begin
            for (int i = 0; i < 8; i++) vin[i] = 10'($urandom);
            write_mask(8'($urandom));
            write_chan(3'($urandom));
            run_conv(($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0, 0);
            clear_done();
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule